// File: doc/BRIEF.md
# Micro-Program Sequencer with Return Register

This block produces the address of the next microinstruction for a microcoded control unit. It holds a 7-bit counter whose value is driven continuously onto the microinstruction address output. A 3-bit operation code is sampled at every rising clock edge and selects the counter's next value. The choices are: the next sequential address, either of two addresses supplied by external opcode-mapping logic, zero, a jump target taken from the current microinstruction, or a saved return address.

One level of subroutine support is provided by a single return register. A call operation updates two things on the same edge: the return register receives the current address plus one, and the counter takes the jump target. A later return operation loads the counter from the return register. A flag shows when the counter is at address zero, which is the entry point of instruction fetch. The mapping memories and the microinstruction decoder sit outside this block.

Top module: `upc_sequencer`

## Requirements
- R1: With `rst_n` low at a rising edge, the counter and the return register both become 0. A return operation issued straight after reset therefore yields address 0.
- R2: Operation code 3'b000 sets the counter to its current value plus one. Counting from 127 gives 0.
- R3: Operation code 3'b001 loads the counter from `map_a`. Operation code 3'b010 loads the counter from `map_b`.
- R4: Operation code 3'b011 sets the counter to 0.
- R5: Operation code 3'b100 loads the counter from `jump_addr`.
- R6: Operation code 3'b101 loads the counter from the return register.
- R7: On a single edge, operation code 3'b110 writes the current counter value plus one into the return register and loads `jump_addr` into the counter. A call made at address 127 saves 0.
- R8: Operation code 3'b111 leaves the counter unchanged, whatever the data inputs hold.
- R9: `new_instr` is high exactly when `uaddr` is 0.
- R10: Every operation code except 3'b110 leaves the return register unchanged. This is observed through a later 3'b101.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl | input | 3 | Operation code selecting the next address |
| map_a | input | 7 | Address from the first opcode-mapping source |
| map_b | input | 7 | Address from the second opcode-mapping source |
| jump_addr | input | 7 | Jump target from the current microinstruction |
| uaddr | output | 7 | Current counter value, used as the microinstruction address |
| new_instr | output | 1 | High while the counter is at address 0 |

## Verification
The call operation performs two tasks on one edge: it saves the return address and it takes the jump. The bench forces this overlap in three ways. It places calls at ordinary addresses. It places a call at address 127, where the saved value must wrap to 0. It issues a call on one edge and a return on the very next. Each case is judged by comparing the counter against a behavioural model on every clock, and by a later return operation that shows whether the saved value was the pre-jump address plus one.

// File: rtl/upc_pkg.sv
// Package: shared operation codes for the micro-program sequencer.
// Assumes the 3-bit code arrives already decoded from the microinstruction.
package upc_pkg;
    typedef enum logic [2:0] {
        UPC_INC   = 3'b000,
        UPC_MAP_A = 3'b001,
        UPC_MAP_B = 3'b010,
        UPC_CLR   = 3'b011,
        UPC_JUMP  = 3'b100,
        UPC_RET   = 3'b101,
        UPC_CALL  = 3'b110,
        UPC_HOLD  = 3'b111
    } upc_op_e;
endpackage

// File: rtl/upc_next_sel.sv
// Module: combinational next-address selection.
// Picks the counter's next value from the operation code. It also produces the
// return-register write enable and data. Assumes all inputs are valid each cycle.
module upc_next_sel
    import upc_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  upc_op_e           op,
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] map_a,
    input  logic [ADDR_W-1:0] map_b,
    input  logic [ADDR_W-1:0] jump,
    input  logic [ADDR_W-1:0] ret,
    output logic [ADDR_W-1:0] nxt,
    output logic              ret_wr,
    output logic [ADDR_W-1:0] ret_val
);
    logic [ADDR_W-1:0] inc_val;

    // Sequential successor; the modulo-2^ADDR_W add gives the wrap to zero.
    always_comb inc_val = cur + ADDR_W'(1);

    // Next counter value chosen by the operation code.
    always_comb begin
        unique case (op)
            UPC_INC:   nxt = inc_val;
            UPC_MAP_A: nxt = map_a;
            UPC_MAP_B: nxt = map_b;
            UPC_CLR:   nxt = '0;
            UPC_JUMP:  nxt = jump;
            UPC_RET:   nxt = ret;
            UPC_CALL:  nxt = jump;
            default:   nxt = cur;
        endcase
    end

    // The return register is written only by a call, and it saves the successor.
    always_comb begin
        ret_wr  = (op == UPC_CALL);
        ret_val = inc_val;
    end
endmodule

// File: rtl/upc_ret_reg.sv
// Module: single-entry return-address register.
// Loads on a write enable and holds otherwise. Synchronous active-low reset to 0.
module upc_ret_reg #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] d,
    output logic [ADDR_W-1:0] q
);
    // Capture the return address on a call.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= d;
    end
endmodule

// File: rtl/upc_count_reg.sv
// Module: the micro-program counter state register and its zero detector.
// Takes a new value on every edge. Synchronous active-low reset to 0.
module upc_count_reg #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] d,
    output logic [ADDR_W-1:0] q,
    output logic              is_zero
);
    // Register the selected next address.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // Flag the instruction-fetch entry address.
    always_comb is_zero = (q == '0);
endmodule

// File: rtl/upc_sequencer.sv
// Module: top of the micro-program sequencer.
// Joins the next-address selector, the counter and the return register.
// Assumes ctrl, map_a, map_b and jump_addr are stable around the rising edge.
module upc_sequencer
    import upc_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        ctrl,
    input  logic [ADDR_W-1:0] map_a,
    input  logic [ADDR_W-1:0] map_b,
    input  logic [ADDR_W-1:0] jump_addr,
    output logic [ADDR_W-1:0] uaddr,
    output logic              new_instr
);
    upc_op_e           op;
    logic [ADDR_W-1:0] nxt;
    logic [ADDR_W-1:0] ret_q;
    logic [ADDR_W-1:0] ret_d;
    logic              ret_wr;

    // Interpret the raw code as an operation.
    always_comb op = upc_op_e'(ctrl);

    upc_next_sel #(.ADDR_W(ADDR_W)) u_sel (
        .op(op), .cur(uaddr), .map_a(map_a), .map_b(map_b), .jump(jump_addr),
        .ret(ret_q), .nxt(nxt), .ret_wr(ret_wr), .ret_val(ret_d)
    );

    upc_ret_reg #(.ADDR_W(ADDR_W)) u_ret (
        .clk(clk), .rst_n(rst_n), .wr_en(ret_wr), .d(ret_d), .q(ret_q)
    );

    upc_count_reg #(.ADDR_W(ADDR_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .d(nxt), .q(uaddr), .is_zero(new_instr)
    );
endmodule

// File: rtl/upc_sequencer_chk.sv
// Module: property checker for the sequencer, attached with bind.
// Observes the top-level ports and the return register output.
module upc_sequencer_chk #(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        ctrl,
    input logic [ADDR_W-1:0] map_a,
    input logic [ADDR_W-1:0] map_b,
    input logic [ADDR_W-1:0] jump_addr,
    input logic [ADDR_W-1:0] uaddr,
    input logic              new_instr,
    input logic [ADDR_W-1:0] ret_q
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (uaddr == '0 && ret_q == '0));
    // R2
    inc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl == 3'b000 |=> uaddr == ADDR_W'($past(uaddr) + ADDR_W'(1)));
    // R3
    map_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl == 3'b001 |=> uaddr == $past(map_a));
    // R3
    map_b_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl == 3'b010 |=> uaddr == $past(map_b));
    // R4
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl == 3'b011 |=> uaddr == '0);
    // R5
    jump_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl == 3'b100 |=> uaddr == $past(jump_addr));
    // R6
    return_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl == 3'b101 |=> uaddr == $past(ret_q));
    // R7
    call_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl == 3'b110 |=> (uaddr == $past(jump_addr) &&
                            ret_q == ADDR_W'($past(uaddr) + ADDR_W'(1))));
    // R8
    hold_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl == 3'b111 |=> $stable(uaddr));
    // R9
    fetch_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl == 3'b011 |=> new_instr);
    // R10
    ret_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl != 3'b110 |=> $stable(ret_q));
endmodule

bind upc_sequencer upc_sequencer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .map_a(map_a), .map_b(map_b),
    .jump_addr(jump_addr), .uaddr(uaddr), .new_instr(new_instr), .ret_q(ret_q)
);

// File: tb/sim_upc_sequencer.sv
`timescale 1ns/1ps
module sim_upc_sequencer;
    localparam int W    = 7;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   ctrl = 3'b111;
    logic [W-1:0] map_a = '0, map_b = '0, jump_addr = '0;
    logic [W-1:0] uaddr;
    logic         new_instr;

    int m_pc  = 0;
    int m_ret = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    upc_sequencer #(.ADDR_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .map_a(map_a), .map_b(map_b),
        .jump_addr(jump_addr), .uaddr(uaddr), .new_instr(new_instr)
    );

    function automatic string tag_of(input int c);
        case (c)
            0: return "R2";
            1, 2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6/R10";
            6: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic compare(input string tag);
        n_chk++;
        if (int'(uaddr) != m_pc) begin
            n_bad++;
            $display("FAIL %s uaddr actual=%0d expected=%0d", tag, uaddr, m_pc);
        end
        n_chk++;
        if (new_instr !== (m_pc == 0)) begin
            n_bad++;
            $display("FAIL R9 (%s) new_instr actual=%0b expected=%0b", tag, new_instr, m_pc == 0);
        end
    endtask

    // One cycle: drive at the falling edge, update the model at the rising edge, compare at the next falling edge.
    task automatic step(input int c, input int a, input int b, input int j, input bit rst, input string tag);
        ctrl = 3'(c); map_a = W'(a); map_b = W'(b); jump_addr = W'(j); rst_n = !rst;
        @(posedge clk);
        if (rst) begin m_pc = 0; m_ret = 0; end
        else begin
            case (c)
                0: m_pc = (m_pc + 1) & MASK;
                1: m_pc = a & MASK;
                2: m_pc = b & MASK;
                3: m_pc = 0;
                4: m_pc = j & MASK;
                5: m_pc = m_ret;
                6: begin m_ret = (m_pc + 1) & MASK; m_pc = j & MASK; end
                default: ;
            endcase
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(8 * 5000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(7, 5, 6, 7, 1, "R1");
        step(7, 5, 6, 7, 1, "R1");
        step(5, 0, 0, 0, 0, "R1");          // return after reset yields 0
        step(0, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, "R2");
        step(1, 33, 90, 0, 0, "R3");
        step(2, 33, 90, 0, 0, "R3");
        step(7, 11, 12, 13, 0, "R8");
        step(3, 0, 0, 0, 0, "R4");
        step(4, 0, 0, 126, 0, "R5");
        step(0, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, "R2");          // 127 -> 0 wrap, new_instr high
        step(4, 0, 0, 10, 0, "R5");
        step(6, 0, 0, 50, 0, "R7");         // saves 11
        step(0, 0, 0, 0, 0, "R2");
        step(1, 3, 0, 0, 0, "R3");
        step(7, 1, 2, 3, 0, "R8");
        step(5, 0, 0, 0, 0, "R10");         // still 11
        step(4, 0, 0, 127, 0, "R5");
        step(6, 0, 0, 20, 0, "R7");         // call at 127 saves 0
        step(5, 0, 0, 0, 0, "R7");          // back-to-back return -> 0
        step(6, 0, 0, 64, 0, "R7");
        step(5, 0, 0, 0, 0, "R6");          // returns 1
        step(6, 0, 0, 99, 0, "R7");
        step(7, 0, 0, 0, 1, "R1");          // reset clears return register
        step(5, 0, 0, 0, 0, "R1");
        for (int i = 0; i < 400; i++) begin
            int c;
            c = $urandom_range(0, 7);
            step(c, $urandom_range(0, MASK), $urandom_range(0, MASK),
                 $urandom_range(0, MASK), 1'b0, tag_of(c));
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule